// File: doc/BRIEF.md
# Bounded Upward-Growing Stack Pointer Unit

This unit owns the stack pointer of a word-organised data memory that uses 16-bit byte addresses. The pointer always holds the address of the next free word, and the stack grows toward higher addresses. The unit accepts single-word push and pop requests, two-word call frames and exception frames, writes to a programmable upper limit, and direct writes to the pointer itself. For each request it drives the memory address, the write data and the write and read strobes in the same cycle. Read data from the memory is passed back to the requester in that cycle.

Every stack access is checked before it is allowed to reach memory. The upper check compares the effective address with the limit register and traps only once a push would land past the limit. The lower check protects the special-register region below a fixed floor of 0x0800. A request that fails either check is suppressed and sets a sticky trap flag. The requester clears the flags explicitly.

Top module: `stk_ptr_unit`

## Requirements
- R1: After reset the pointer is 0x0800, both trap flags are clear and busy_o is low. The limit register has no defined value until it is first written, and no overflow check is made before that first write.
- R2: An accepted push drives mem_we_o with mem_addr_o equal to the current pointer and mem_wdata_o equal to push_data_i. The pointer then increases by 2.
- R3: An accepted pop decreases the pointer by 2 and drives mem_re_o with mem_addr_o equal to the new value, all in the same cycle. rd_data_o carries mem_rdata_i, and rd_valid_o is high in that cycle.
- R4: Bit 0 is forced to 0 on every write to the pointer (sp_we_i) and on every write to the limit (lim_we_i).
- R5: A push whose address is greater than the limit sets ovf_trap_o. The write is suppressed and the pointer does not change. A push whose address equals the limit is allowed.
- R6: A push or pop whose address would be below 0x0800 sets unf_trap_o. The access is suppressed and the pointer does not change.
- R7: A trap flag stays set until clr_trap_i is asserted. If a new trap and a clear fall in the same cycle, the flag ends up set.
- R8: A call frame (call_i) writes pc_i[15:0] in its first cycle. In the next cycle it writes a second word with pc_i[22:16] in bits 6:0 and zeros in bits 15:7.
- R9: An exception frame (exc_i) writes pc_i[15:0] in its first cycle. The second word holds status_i in bits 15:8, 0 in bit 7 and pc_i[22:16] in bits 6:0.
- R10: A frame occupies two consecutive cycles. busy_o is high in the second cycle, and any push, pop, frame or pointer-write request in that cycle is ignored. If the first word traps, no second cycle follows.
- R11: In the cycle after a limit write, busy_o is high and all stack and pointer-write requests are ignored. This includes the pop that would read through the pointer.
- R12: When requests fall in the same cycle, a pointer write takes priority over any stack operation. Among stack operations the order is call, then exception, then push, then pop. A push in the same cycle as a limit write is checked against the old limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Single-word push request |
| pop_i | input | 1 | Single-word pop request |
| call_i | input | 1 | Call-frame push request |
| exc_i | input | 1 | Exception-frame push request |
| push_data_i | input | 16 | Data for a single-word push |
| pc_i | input | 23 | Program counter for a frame push |
| status_i | input | 8 | Status byte for an exception frame |
| lim_we_i | input | 1 | Limit register write strobe |
| lim_data_i | input | 16 | Limit register write value |
| sp_we_i | input | 1 | Direct pointer write strobe |
| sp_data_i | input | 16 | Direct pointer write value |
| clr_trap_i | input | 1 | Clears both trap flags |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 16 | Memory read data |
| rd_data_o | output | 16 | Popped word |
| rd_valid_o | output | 1 | Popped word valid |
| sp_o | output | 16 | Current stack pointer |
| busy_o | output | 1 | Requests are ignored this cycle |
| ovf_trap_o | output | 1 | Sticky overflow trap |
| unf_trap_o | output | 1 | Sticky underflow trap |

## Verification
Two cases put functions into the same cycle. In the first, a limit write coincides with a push. The bench writes a new limit that equals the pointer while the old limit lies below it, so a trap shows the push was judged against the old value, and the following cycle must ignore a request. In the second, a trap clear coincides with a fresh underflow, and the flag must remain set. The bench also issues push and pop together, and a pointer write together with a push. Pointer and memory contents after these cases show which request won.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_POP,
    OP_PUSH,
    OP_CALL,
    OP_EXC,
    OP_FRAME_HI
  } stk_op_e;
endpackage

// File: rtl/stk_limit.sv
module stk_limit #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lim_we_i,
  input  logic [AW-1:0] lim_data_i,
  output logic [AW-1:0] lim_o,
  output logic          lim_set_o,
  output logic          hazard_o
);
  logic [AW-1:0] lim_q;
  logic          set_q;
  logic          haz_q;

  // limit value intentionally not reset
  always_ff @(posedge clk_i) begin
    if (lim_we_i) lim_q <= {lim_data_i[AW-1:1], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q <= 1'b0;
      haz_q <= 1'b0;
    end else begin
      if (lim_we_i) set_q <= 1'b1;
      haz_q <= lim_we_i;
    end
  end

  assign lim_o     = lim_q;
  assign lim_set_o = set_q;
  assign hazard_o  = haz_q;

  assert_lim_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_q |-> !lim_q[0]);
endmodule

// File: rtl/stk_bound.sv
module stk_bound #(
  parameter int            AW    = 16,
  parameter logic [AW-1:0] FLOOR = 'h0800
) (
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] lim_i,
  input  logic          lim_set_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam logic [AW-1:0] STEP     = AW'(2);
  localparam logic [AW-1:0] RD_FLOOR = FLOOR + STEP;

  assign ovf_o = wr_i & lim_set_i & (sp_i > lim_i);
  // pop address is sp-2; compare sp against floor+2 so a wrap cannot hide it
  assign unf_o = (wr_i & (sp_i < FLOOR)) | (rd_i & (sp_i < RD_FLOOR));
endmodule

// File: rtl/stk_frame.sv
module stk_frame #(
  parameter int DW  = 16,
  parameter int PCW = 23,
  parameter int STW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           exc_i,
  input  logic [PCW-1:0] pc_i,
  input  logic [STW-1:0] status_i,
  output logic           pending_o,
  output logic [DW-1:0]  lo_word_o,
  output logic [DW-1:0]  hi_word_o
);
  localparam int HI_W  = PCW - DW;
  localparam int PAD_C = DW - HI_W;
  localparam int PAD_E = DW - STW - HI_W;

  logic          pend_q;
  logic [DW-1:0] hi_q;
  logic [DW-1:0] hi_call;
  logic [DW-1:0] hi_exc;

  assign hi_call = {{PAD_C{1'b0}}, pc_i[PCW-1:DW]};

  generate
    if (PAD_E > 0) begin : g_pad
      assign hi_exc = {status_i, {PAD_E{1'b0}}, pc_i[PCW-1:DW]};
    end else begin : g_nopad
      assign hi_exc = {status_i, pc_i[PCW-1:DW]};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      hi_q   <= '0;
    end else begin
      pend_q <= start_i;
      if (start_i) hi_q <= exc_i ? hi_exc : hi_call;
    end
  end

  assign pending_o = pend_q;
  assign lo_word_o = pc_i[DW-1:0];
  assign hi_word_o = hi_q;

  assert_no_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !start_i);
  assert_call_hi_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !exc_i) |=> !hi_q[DW-1]);
endmodule

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit
  import stk_pkg::*;
#(
  parameter int            AW    = 16,
  parameter int            DW    = 16,
  parameter int            PCW   = 23,
  parameter int            STW   = 8,
  parameter logic [AW-1:0] FLOOR = 'h0800
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic           call_i,
  input  logic           exc_i,
  input  logic [DW-1:0]  push_data_i,
  input  logic [PCW-1:0] pc_i,
  input  logic [STW-1:0] status_i,
  input  logic           lim_we_i,
  input  logic [AW-1:0]  lim_data_i,
  input  logic           sp_we_i,
  input  logic [AW-1:0]  sp_data_i,
  input  logic           clr_trap_i,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic           mem_we_o,
  output logic           mem_re_o,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic [DW-1:0]  rd_data_o,
  output logic           rd_valid_o,
  output logic [AW-1:0]  sp_o,
  output logic           busy_o,
  output logic           ovf_trap_o,
  output logic           unf_trap_o
);
  localparam logic [AW-1:0] STEP = AW'(2);

  logic [AW-1:0] sp_q;
  logic [AW-1:0] lim_w;
  logic          lim_set_w;
  logic          hazard_w;
  logic          frame_pend_w;
  logic [DW-1:0] lo_word_w;
  logic [DW-1:0] hi_word_w;
  logic          ovf_w, unf_w, ok_w;
  logic          is_wr, is_rd;
  logic          busy_w, sp_take_w, frame_start_w;
  logic          ovf_q, unf_q;
  stk_op_e       op;

  stk_limit #(.AW(AW)) u_limit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lim_we_i   (lim_we_i),
    .lim_data_i (lim_data_i),
    .lim_o      (lim_w),
    .lim_set_o  (lim_set_w),
    .hazard_o   (hazard_w)
  );

  assign busy_w    = frame_pend_w | hazard_w;
  assign sp_take_w = sp_we_i & ~busy_w;

  always_comb begin
    if (frame_pend_w)          op = OP_FRAME_HI;
    else if (busy_w | sp_we_i) op = OP_NONE;
    else if (call_i)           op = OP_CALL;
    else if (exc_i)            op = OP_EXC;
    else if (push_i)           op = OP_PUSH;
    else if (pop_i)            op = OP_POP;
    else                       op = OP_NONE;
  end

  assign is_wr = (op == OP_PUSH) || (op == OP_CALL) || (op == OP_EXC) || (op == OP_FRAME_HI);
  assign is_rd = (op == OP_POP);

  stk_bound #(.AW(AW), .FLOOR(FLOOR)) u_bound (
    .sp_i      (sp_q),
    .lim_i     (lim_w),
    .lim_set_i (lim_set_w),
    .wr_i      (is_wr),
    .rd_i      (is_rd),
    .ovf_o     (ovf_w),
    .unf_o     (unf_w)
  );

  assign ok_w          = ~ovf_w & ~unf_w;
  assign frame_start_w = ((op == OP_CALL) || (op == OP_EXC)) & ok_w;

  stk_frame #(.DW(DW), .PCW(PCW), .STW(STW)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (frame_start_w),
    .exc_i     (op == OP_EXC),
    .pc_i      (pc_i),
    .status_i  (status_i),
    .pending_o (frame_pend_w),
    .lo_word_o (lo_word_w),
    .hi_word_o (hi_word_w)
  );

  always_comb begin
    unique case (op)
      OP_PUSH:        mem_wdata_o = push_data_i;
      OP_CALL,
      OP_EXC:         mem_wdata_o = lo_word_w;
      OP_FRAME_HI:    mem_wdata_o = hi_word_w;
      default:        mem_wdata_o = '0;
    endcase
  end

  assign mem_we_o   = is_wr & ok_w;
  assign mem_re_o   = is_rd & ok_w;
  assign mem_addr_o = is_rd ? sp_q - STEP : sp_q;
  assign rd_data_o  = mem_rdata_i;
  assign rd_valid_o = mem_re_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= FLOOR;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (sp_take_w)     sp_q <= {sp_data_i[AW-1:1], 1'b0};
      else if (mem_we_o) sp_q <= sp_q + STEP;
      else if (mem_re_o) sp_q <= sp_q - STEP;
      ovf_q <= ovf_w | (ovf_q & ~clr_trap_i);
      unf_q <= unf_w | (unf_q & ~clr_trap_i);
    end
  end

  assign sp_o       = sp_q;
  assign busy_o     = busy_w;
  assign ovf_trap_o = ovf_q;
  assign unf_trap_o = unf_q;

  assert_sp_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sp_q[0]);
  assert_push_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> sp_q == $past(sp_q) + STEP);
  assert_pop_retreat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> sp_q == $past(sp_q) - STEP);
  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !(lim_set_w && (mem_addr_o > lim_w)));
  assert_above_floor_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> (mem_addr_o >= FLOOR));
  assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_trap_i) |=> ovf_q);
  assert_unf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_q && !clr_trap_i) |=> unf_q);
  assert_lim_stall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_we_i |=> (busy_o && !mem_re_o));
  assert_rw_exclusive_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
endmodule

// File: tb/stk_ptr_unit_tb.sv
`timescale 1ns/1ps
module stk_ptr_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 0, pop_i = 0, call_i = 0, exc_i = 0;
  logic [15:0] push_data_i = '0;
  logic [22:0] pc_i = '0;
  logic [7:0]  status_i = '0;
  logic        lim_we_i = 0;
  logic [15:0] lim_data_i = '0;
  logic        sp_we_i = 0;
  logic [15:0] sp_data_i = '0;
  logic        clr_trap_i = 0;
  logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i, rd_data_o, sp_o;
  logic        mem_we_o, mem_re_o, rd_valid_o, busy_o, ovf_trap_o, unf_trap_o;

  int checks = 0;
  int errors = 0;

  logic [15:0] ram [0:2047];

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i) if (mem_we_o) ram[mem_addr_o[11:1]] <= mem_wdata_o;
  assign mem_rdata_i = ram[mem_addr_o[11:1]];

  stk_ptr_unit u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic clear_in();
    push_i = 0; pop_i = 0; call_i = 0; exc_i = 0;
    lim_we_i = 0; sp_we_i = 0; clr_trap_i = 0;
  endtask

  task automatic do_push(input logic [15:0] d);
    push_i = 1; push_data_i = d;
    cyc();
    clear_in();
  endtask

  task automatic set_lim(input logic [15:0] v);
    lim_we_i = 1; lim_data_i = v;
    cyc();
    clear_in();
    cyc();
  endtask

  task automatic clr_traps();
    clr_trap_i = 1;
    cyc();
    clear_in();
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20;
    @(negedge clk_i);
    chk("R1 sp", sp_o, 16'h0800);
    chk("R1 ovf", ovf_trap_o, 0);
    chk("R1 unf", unf_trap_o, 0);
    chk("R1 busy", busy_o, 0);
    rst_ni = 1;
    cyc();

    // R1: no limit written yet, pushes never overflow
    for (int i = 0; i < 3; i++) do_push(16'h1110 + 16'(i));
    chk("R1 no ovf before limit", ovf_trap_o, 0);
    chk("R2 sp", sp_o, 16'h0806);
    for (int i = 0; i < 3; i++) begin
      pop_i = 1; #1;
      chk("R3 rd_valid", rd_valid_o, 1);
      chk("R3 addr", mem_addr_o, 16'h0806 - 16'(2 * (i + 1)));
      chk("R3 data", rd_data_o, 16'h1112 - 16'(i));
      cyc(); clear_in();
    end
    chk("R3 sp", sp_o, 16'h0800);

    // R6 underflow at floor, R7 sticky and set-beats-clear
    pop_i = 1; #1;
    chk("R6 re suppressed", mem_re_o, 0);
    cyc(); clear_in();
    chk("R6 unf", unf_trap_o, 1);
    chk("R6 sp", sp_o, 16'h0800);
    cyc();
    chk("R7 sticky", unf_trap_o, 1);
    pop_i = 1; clr_trap_i = 1;
    cyc(); clear_in();
    chk("R7 set wins", unf_trap_o, 1);
    clr_traps();
    chk("R7 clear", unf_trap_o, 0);

    // R11 stall after limit write
    lim_we_i = 1; lim_data_i = 16'h0821;
    cyc(); clear_in();
    chk("R11 busy", busy_o, 1);
    push_i = 1; push_data_i = 16'hDEAD; #1;
    chk("R11 we blocked", mem_we_o, 0);
    cyc(); clear_in();
    chk("R11 sp", sp_o, 16'h0800);
    chk("R11 busy drop", busy_o, 0);

    // R5 sweep up to limit 0x0820
    for (int i = 0; i <= 16; i++) begin
      push_i = 1; push_data_i = 16'hA000 + 16'(i); #1;
      chk("R2 we", mem_we_o, 1);
      chk("R2 addr", mem_addr_o, 16'h0800 + 16'(2 * i));
      chk("R2 wdata", mem_wdata_o, 16'hA000 + 16'(i));
      cyc(); clear_in();
    end
    chk("R5 at-limit ok", ovf_trap_o, 0);
    chk("R5 sp", sp_o, 16'h0822);
    push_i = 1; push_data_i = 16'hBEEF; #1;
    chk("R5 we suppressed", mem_we_o, 0);
    cyc(); clear_in();
    chk("R5 ovf", ovf_trap_o, 1);
    chk("R5 sp kept", sp_o, 16'h0822);
    clr_traps();
    for (int i = 0; i <= 16; i++) begin
      pop_i = 1; #1;
      chk("R3 lifo", rd_data_o, 16'hA010 - 16'(i));
      cyc(); clear_in();
    end
    chk("R3 sp back", sp_o, 16'h0800);

    // R4 alignment sweep
    for (int v = 0; v < 16; v++) begin
      sp_we_i = 1; sp_data_i = 16'h0900 + 16'(v);
      cyc(); clear_in();
      chk("R4 sp align", sp_o, 16'h0900 + 16'(v & 14));
    end
    sp_we_i = 1; sp_data_i = 16'h0903;
    cyc(); clear_in();

    // R12 limit write with push: old limit 0x0820 is used
    lim_we_i = 1; lim_data_i = 16'h0903; push_i = 1; push_data_i = 16'h5555;
    cyc(); clear_in();
    chk("R12 old limit", ovf_trap_o, 1);
    chk("R12 sp", sp_o, 16'h0902);
    cyc();
    clr_traps();
    do_push(16'h6666);
    chk("R4 limit aligned, equal ok", ovf_trap_o, 0);
    chk("R5 sp", sp_o, 16'h0904);
    do_push(16'h7777);
    chk("R5 past limit", ovf_trap_o, 1);
    chk("R5 sp kept", sp_o, 16'h0904);
    clr_traps();

    // R12 priorities
    sp_we_i = 1; sp_data_i = 16'h0A00; push_i = 1; push_data_i = 16'h1234; #1;
    chk("R12 sp write beats push", mem_we_o, 0);
    cyc(); clear_in();
    chk("R12 sp", sp_o, 16'h0A00);
    set_lim(16'h0FFE);
    push_i = 1; pop_i = 1; push_data_i = 16'h4321;
    cyc(); clear_in();
    chk("R12 push beats pop", sp_o, 16'h0A02);
    chk("R12 push data", ram[11'h500], 16'h4321);

    // R8 call frame
    call_i = 1; pc_i = 23'h5ABCDE; #1;
    chk("R8 lo", mem_wdata_o, 16'hBCDE);
    chk("R8 lo addr", mem_addr_o, 16'h0A02);
    cyc(); clear_in();
    pc_i = '0;
    chk("R10 busy", busy_o, 1);
    push_i = 1; push_data_i = 16'hFFFF; #1;
    chk("R8 hi", mem_wdata_o, 16'h005A);
    chk("R8 hi addr", mem_addr_o, 16'h0A04);
    cyc(); clear_in();
    chk("R10 push ignored", sp_o, 16'h0A06);
    chk("R10 busy drop", busy_o, 0);

    // R9 exception frame
    exc_i = 1; pc_i = 23'h7F1234; status_i = 8'hC3;
    cyc(); clear_in();
    cyc();
    chk("R9 lo", ram[11'h503], 16'h1234);
    chk("R9 hi", ram[11'h504], 16'hC37F);
    chk("R9 sp", sp_o, 16'h0A0A);

    // R10 second frame word overflows
    set_lim(16'h0A0A);
    call_i = 1; pc_i = 23'h012345;
    cyc(); clear_in();
    chk("R10 second cycle", busy_o, 1);
    #1;
    chk("R10 hi suppressed", mem_we_o, 0);
    cyc();
    chk("R10 ovf", ovf_trap_o, 1);
    chk("R10 sp", sp_o, 16'h0A0C);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule